// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block makes the accept or reject decision for a received Ethernet frame from its 48-bit destination address alone. The address arrives as six bytes on a byte stream with a valid strobe and a start marker on the first byte. While the bytes arrive, the block compares them against the programmed station address, tracks whether every byte is 0xFF, and folds each byte into a CRC register that yields a 6-bit hash index.

One cycle after the sixth byte is taken, the block pulses a decision strobe and presents the accept flag and the hash index. A frame is accepted on an exact station-address match, on the broadcast address, or on a multicast address whose bit in a 64-bit hash table is set. Each of these three paths has its own enable input. The table is supplied as a low and a high 32-bit word. The station address, the enables and the table are configuration inputs that must stay stable while an address is in flight.

Top module: `mhf_filter`

## Requirements
- R1: While and after reset, before any address is completed, dec_valid, accept and hash_idx are all 0.
- R2: A byte is taken when addr_valid is 1. A byte taken with addr_start 1 is address byte 0, and the next five taken bytes are bytes 1 to 5. Byte k is compared with station_addr[8k+7:8k], so station_addr[7:0] holds the first byte on the wire.
- R3: The hash is a CRC-32 register preset to 0xFFFFFFFF, shifted left with polynomial 0x04C11DB7. Bytes are fed in arrival order, each byte bit 0 first. For each bit, if CRC bit 31 XOR the data bit is 1, the register shifts left and XORs in the polynomial; otherwise it only shifts left. No final inversion is applied. hash_idx is CRC bits 28 down to 23.
- R4: dec_valid is 1 for exactly one cycle, the cycle after the sixth byte is taken. accept and hash_idx change only together with that pulse and hold their values otherwise.
- R5: When en_perfect is 1 and all six bytes equal the station address, accept is 1.
- R6: The broadcast address (all six bytes 0xFF) is accepted if and only if en_bcast is 1, unless it also matches the station address under R5. The hash table is not consulted for it.
- R7: A non-broadcast address whose byte 0 has bit 0 set is a multicast address. It is accepted when en_mcast is 1 and table bit idx is set. For idx 0 to 31 that bit is hash_lo[idx]; for idx 32 to 63 it is hash_hi[idx-32].
- R8: Any other address is rejected, including a unicast address that does not match the station address, and any address when all three enables are 0.
- R9: Bytes taken when no address is in progress (after a sixth byte, or after reset, without a new addr_start) are ignored and produce no dec_valid pulse. Cycles with addr_valid 0 are ignored.
- R10: addr_start on a byte in the middle of an address discards the partial address and begins a new one with that byte as byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | Address byte strobe |
| addr_start | input | 1 | Marks the first address byte |
| addr_byte | input | 8 | Address byte |
| station_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| hash_lo | input | 32 | Hash table bits 0 to 31 |
| hash_hi | input | 32 | Hash table bits 32 to 63 |
| en_perfect | input | 1 | Enable station-address match |
| en_mcast | input | 1 | Enable multicast hash acceptance |
| en_bcast | input | 1 | Enable broadcast acceptance |
| dec_valid | output | 1 | One-cycle decision strobe |
| accept | output | 1 | Frame accept flag, held between decisions |
| hash_idx | output | 6 | Hash index of the last address, held between decisions |

## Verification
Directed addresses cover the station address with its enable on and off, the broadcast address with the table full but broadcast disabled (this separates the broadcast path from the hash path), and multicast addresses whose index falls in the low and in the high table word with the bit set and cleared (this exposes a swapped word or a wrong index slice). Stream patterns with idle gaps between bytes, extra bytes after the sixth, bytes without a start marker and a restart in mid-address check the byte counting and the timing of the strobe. Random addresses, with a mix of multicast, unicast and station-derived values under random tables and enables, are compared with a bench CRC model, so a bit-order or byte-order error in the hash shows up as a wrong index.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CRC_W   = 32;
  localparam logic [CRC_W-1:0] CRC_POLY   = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_PRESET = '1;
  localparam int unsigned IDX_W   = 6;
  localparam int unsigned IDX_LSB = 23;
  localparam int unsigned WORD_W  = 32;

  // One byte folded in, bit 0 first, no reflection of the register.
  function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] c_in,
                                                     input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] c;
    c = c_in;
    for (int j = 0; j < BYTE_W; j++) begin
      if (c[CRC_W-1] ^ b[j]) c = (c << 1) ^ CRC_POLY;
      else                   c = c << 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/mhf_crc.sv
module mhf_crc
  import mhf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  crc_next
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic [CRC_W-1:0] seed;

  always_comb begin
    seed     = first ? CRC_PRESET : crc_q;
    crc_next = crc_fold_byte(seed, data);
    crc_d    = take ? crc_next : crc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_PRESET;
    else        crc_q <= crc_d;
  end
endmodule

// File: rtl/mhf_addr_track.sv
module mhf_addr_track
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned ADDR_W = ADDR_BYTES * BYTE_W,
  localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_valid,
  input  logic              addr_start,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic [ADDR_W-1:0] station_addr,
  output logic              take,
  output logic              first,
  output logic              last,
  output logic              perf_next,
  output logic              bcast_next,
  output logic              mcast_next
);
  localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, pos;
  logic             perf_q, bcast_q, mcast_q;
  logic [BYTE_W-1:0] st_byte;

  always_comb begin
    first      = addr_valid && addr_start;
    take       = addr_valid && (addr_start || (cnt_q != IDLE_CNT));
    pos        = addr_start ? '0 : cnt_q;
    last       = take && (pos == LAST_POS);
    st_byte    = station_addr[pos*BYTE_W +: BYTE_W];
    perf_next  = (first ? 1'b1 : perf_q)  && (addr_byte == st_byte);
    bcast_next = (first ? 1'b1 : bcast_q) && (addr_byte == '1);
    mcast_next = first ? addr_byte[0] : mcast_q;
    cnt_d      = take ? pos + CNT_W'(1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= IDLE_CNT;
      perf_q  <= 1'b0;
      bcast_q <= 1'b0;
      mcast_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (take) begin
        perf_q  <= perf_next;
        bcast_q <= bcast_next;
        mcast_q <= mcast_next;
      end
    end
  end
endmodule

// File: rtl/mhf_filter.sv
module mhf_filter
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  localparam int unsigned ADDR_W = ADDR_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_valid,
  input  logic              addr_start,
  input  logic [7:0]        addr_byte,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic [31:0]       hash_lo,
  input  logic [31:0]       hash_hi,
  input  logic              en_perfect,
  input  logic              en_mcast,
  input  logic              en_bcast,
  output logic              dec_valid,
  output logic              accept,
  output logic [5:0]        hash_idx
);
  localparam int unsigned TBL_BITS = 2 * WORD_W;

  logic              take, first, last;
  logic              perf_next, bcast_next, mcast_next;
  logic [CRC_W-1:0]  crc_next;
  logic [TBL_BITS-1:0] table_bits;
  logic [IDX_W-1:0]  idx_d;
  logic              hit_d, accept_d;

  mhf_addr_track #(.ADDR_BYTES(ADDR_BYTES)) u_track (
    .clk(clk), .rst_n(rst_n),
    .addr_valid(addr_valid), .addr_start(addr_start), .addr_byte(addr_byte),
    .station_addr(station_addr),
    .take(take), .first(first), .last(last),
    .perf_next(perf_next), .bcast_next(bcast_next), .mcast_next(mcast_next)
  );

  mhf_crc u_crc (
    .clk(clk), .rst_n(rst_n),
    .take(take), .first(first), .data(addr_byte),
    .crc_next(crc_next)
  );

  // Broadcast is resolved ahead of the hash lookup.
  always_comb begin
    table_bits = {hash_hi, hash_lo};
    idx_d      = crc_next[IDX_LSB +: IDX_W];
    hit_d      = table_bits[idx_d];
    accept_d   = (en_perfect && perf_next) ||
                 (bcast_next ? en_bcast : (mcast_next && en_mcast && hit_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      accept    <= 1'b0;
      hash_idx  <= '0;
    end else begin
      dec_valid <= last;
      if (last) begin
        accept   <= accept_d;
        hash_idx <= idx_d;
      end
    end
  end
endmodule

// File: rtl/mhf_filter_chk.sv
module mhf_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        addr_valid,
  input logic [31:0] hash_lo,
  input logic [31:0] hash_hi,
  input logic        en_perfect,
  input logic        en_mcast,
  input logic        en_bcast,
  input logic        dec_valid,
  input logic        accept,
  input logic [5:0]  hash_idx
);
  logic [63:0] tbl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tbl_q <= '0;
    else        tbl_q <= {hash_hi, hash_lo};
  end

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  // R4
  strobe_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(addr_valid));

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> ($stable(accept) && $stable(hash_idx)));

  // R8
  all_off_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !$past(en_perfect) && !$past(en_mcast) && !$past(en_bcast)) |-> !accept);

  // R7
  hash_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && accept && !$past(en_perfect) && !$past(en_bcast)) |-> tbl_q[hash_idx]);
endmodule

bind mhf_filter mhf_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid),
  .hash_lo(hash_lo), .hash_hi(hash_hi),
  .en_perfect(en_perfect), .en_mcast(en_mcast), .en_bcast(en_bcast),
  .dec_valid(dec_valid), .accept(accept), .hash_idx(hash_idx)
);

// File: tb/mhf_filter_tb.sv
`timescale 1ns/100ps
module mhf_filter_tb;
  logic        clk, rst_n;
  logic        addr_valid, addr_start;
  logic [7:0]  addr_byte;
  logic [47:0] station_addr;
  logic [31:0] hash_lo, hash_hi;
  logic        en_perfect, en_mcast, en_bcast;
  logic        dec_valid, accept;
  logic [5:0]  hash_idx;

  int checks = 0;
  int errors = 0;

  mhf_filter u_dut (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_start(addr_start),
    .addr_byte(addr_byte), .station_addr(station_addr),
    .hash_lo(hash_lo), .hash_hi(hash_hi),
    .en_perfect(en_perfect), .en_mcast(en_mcast), .en_bcast(en_bcast),
    .dec_valid(dec_valid), .accept(accept), .hash_idx(hash_idx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference hash from the requirement text (R3).
  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int j = 0; j < 8; j++) begin
        fb = c[31] ^ a[8*k + j];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    return c[28:23];
  endfunction

  function automatic logic ref_acc(input logic [47:0] a);
    logic [5:0] i;
    logic       bit_set;
    i = ref_idx(a);
    bit_set = (i < 6'd32) ? hash_lo[i[4:0]] : hash_hi[i[4:0]];
    if (en_perfect && a == station_addr) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return en_bcast;
    if (a[0]) return en_mcast && bit_set;
    return 1'b0;
  endfunction

  // Sends six bytes (byte 0 = a[7:0]) with optional idle gaps; returns
  // at the negedge after the sixth byte's capture edge.
  task automatic send(input logic [47:0] a, input int max_gap);
    for (int k = 0; k < 6; k++) begin
      addr_valid = 1'b1;
      addr_start = (k == 0);
      addr_byte  = a[8*k +: 8];
      @(negedge clk);
      addr_valid = 1'b0;
      addr_start = 1'b0;
      addr_byte  = 8'($urandom);
      if (k < 5 && max_gap > 0) begin
        int g = $urandom_range(max_gap, 0);
        repeat (g) begin
          chk("R4 no strobe mid-address", {31'b0, dec_valid}, 32'd0);
          @(negedge clk);
        end
      end
    end
  endtask

  task automatic run(input string req, input logic [47:0] a, input int max_gap);
    logic       ea;
    logic [5:0] ei;
    ea = ref_acc(a);
    ei = ref_idx(a);
    send(a, max_gap);
    chk({req, " strobe"}, {31'b0, dec_valid}, 32'd1);
    chk({req, " accept"}, {31'b0, accept}, {31'b0, ea});
    chk("R3 hash index", {26'b0, hash_idx}, {26'b0, ei});
    @(negedge clk);
    chk("R4 strobe one cycle", {31'b0, dec_valid}, 32'd0);
    chk("R4 accept held", {31'b0, accept}, {31'b0, ea});
    chk("R4 index held", {26'b0, hash_idx}, {26'b0, ei});
  endtask

  // Set the table bit for a given address's index only.
  task automatic only_bit_of(input logic [47:0] a);
    logic [5:0] i;
    i = ref_idx(a);
    hash_lo = '0;
    hash_hi = '0;
    if (i < 6'd32) hash_lo[i[4:0]] = 1'b1;
    else           hash_hi[i[4:0]] = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] a, lo_a, hi_a;
    logic        found_lo, found_hi;
    void'($urandom(32'h1D5EED));
    rst_n = 1'b0;
    addr_valid = 1'b0; addr_start = 1'b0; addr_byte = '0;
    station_addr = 48'h5A_34_12_CD_AB_02;
    hash_lo = '0; hash_hi = '0;
    en_perfect = 1'b1; en_mcast = 1'b1; en_bcast = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset dec_valid", {31'b0, dec_valid}, 32'd0);
    chk("R1 reset accept", {31'b0, accept}, 32'd0);
    chk("R1 reset hash_idx", {26'b0, hash_idx}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: bytes without a start after reset are ignored
    for (int k = 0; k < 8; k++) begin
      addr_valid = 1'b1; addr_byte = 8'hFF;
      @(negedge clk);
      chk("R9 no start ignored", {31'b0, dec_valid}, 32'd0);
    end
    addr_valid = 1'b0;
    chk("R1 outputs still reset", {25'b0, accept, hash_idx}, 32'd0);

    // R5: perfect match, with and without enable; R2 byte order
    run("R5 perfect on", station_addr, 0);
    chk("R5 perfect accepted", {31'b0, accept}, 32'd1);
    run("R2 reversed order rejected", {station_addr[7:0], station_addr[15:8],
        station_addr[23:16], station_addr[31:24], station_addr[39:32], station_addr[47:40]}, 0);
    chk("R2 reversed order reject", {31'b0, accept}, 32'd0);
    en_perfect = 1'b0;
    run("R8 perfect disabled", station_addr, 2);
    en_perfect = 1'b1;

    // R6: broadcast; table full with broadcast disabled must reject
    hash_lo = '1; hash_hi = '1;
    run("R6 bcast on", 48'hFFFF_FFFF_FFFF, 1);
    chk("R6 bcast accepted", {31'b0, accept}, 32'd1);
    en_bcast = 1'b0;
    run("R6 bcast off table full", 48'hFFFF_FFFF_FFFF, 0);
    chk("R6 bcast rejected", {31'b0, accept}, 32'd0);
    en_bcast = 1'b1;

    // R7: find multicast addresses hashing into each table word
    found_lo = 1'b0; found_hi = 1'b0; lo_a = '0; hi_a = '0;
    for (int n = 0; n < 400 && !(found_lo && found_hi); n++) begin
      a = {16'($urandom), 32'($urandom)};
      a[0] = 1'b1;
      if (ref_idx(a) < 6'd32 && !found_lo) begin lo_a = a; found_lo = 1'b1; end
      if (ref_idx(a) >= 6'd32 && !found_hi) begin hi_a = a; found_hi = 1'b1; end
    end
    only_bit_of(lo_a);
    run("R7 mcast low word bit set", lo_a, 1);
    chk("R7 low word accept", {31'b0, accept}, 32'd1);
    run("R7 mcast high word bit clear", hi_a, 1);
    chk("R7 high word reject", {31'b0, accept}, 32'd0);
    only_bit_of(hi_a);
    run("R7 mcast high word bit set", hi_a, 0);
    chk("R7 high word accept", {31'b0, accept}, 32'd1);
    en_mcast = 1'b0;
    run("R7 mcast disabled", hi_a, 0);
    en_mcast = 1'b1;

    // R8: unicast non-matching with table full
    hash_lo = '1; hash_hi = '1;
    run("R8 unicast mismatch", 48'h0102_0304_0506 & ~48'h1, 0);
    chk("R8 unicast reject", {31'b0, accept}, 32'd0);

    // R9: bytes after the sixth are ignored
    for (int k = 0; k < 7; k++) begin
      addr_valid = 1'b1; addr_byte = 8'($urandom);
      @(negedge clk);
      chk("R9 trailing bytes ignored", {31'b0, dec_valid}, 32'd0);
    end
    addr_valid = 1'b0;

    // R10: restart in mid-address
    for (int k = 0; k < 3; k++) begin
      addr_valid = 1'b1; addr_start = (k == 0); addr_byte = 8'hFF;
      @(negedge clk);
    end
    addr_valid = 1'b0; addr_start = 1'b0;
    run("R10 restart", station_addr, 1);
    chk("R10 restart perfect", {31'b0, accept}, 32'd1);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      hash_lo = $urandom; hash_hi = $urandom;
      en_perfect = 1'($urandom); en_mcast = 1'($urandom); en_bcast = 1'($urandom);
      case ($urandom_range(3, 0))
        0: a = station_addr;
        1: a = 48'hFFFF_FFFF_FFFF;
        default: a = {16'($urandom), 32'($urandom)};
      endcase
      run("R7 random", a, 2);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule